// File: doc/BRIEF.md
# Temperature Sensor Two-Wire Register Slave

This block is the serial front end of a small temperature sensor. A fast system clock samples the two-wire bus lines, SCL and SDA, through a synchronizer. The block finds START and STOP conditions and answers a 7-bit device address. The top four bits of that address are fixed at `1001`, and the low three come from strap inputs. The first byte of a write is a register pointer. It selects one of four registers: the captured temperature, a configuration byte, a lower trip point and an upper trip point. Any further write bytes go into the selected register. A read shifts the selected register out, most significant byte first.

The block also holds the register file, so the alarm logic can use the trip points and the configuration directly. A conversion result arrives on `conv_valid`/`conv_data`. If no read is running, it is stored at once. If a read is running, it waits until the read has finished. If SDA stays low for too long inside a transaction, a watchdog drops the transaction and releases the bus. A single-cycle `read_strobe` marks every completed register read, so an interrupt-style alarm can clear itself.

The protocol engine has these states:
- `ST_IDLE`: the bus is free.
- `ST_ADDR`: the address byte is being received.
- `ST_ADDR_ACK`: the slave acknowledges its address.
- `ST_PTR`: the pointer byte is being received.
- `ST_PTR_ACK`: the slave acknowledges the pointer.
- `ST_WDATA`: a write data byte is being received.
- `ST_WDATA_ACK`: the slave acknowledges a data byte.
- `ST_RDATA`: a read byte is being shifted out.
- `ST_RD_ACK`: the master returns its ACK or NACK.
- `ST_IGNORE`: the slave waits for the bus to free.

Three events take priority over every state, in this order:
1. The timeout goes to `ST_IDLE`.
2. START goes to `ST_ADDR`.
3. STOP goes to `ST_IDLE`.

All other transitions happen on the SCL falling edge that ends a byte or an acknowledge bit:
- From `ST_ADDR`: to `ST_ADDR_ACK` on an address match, otherwise to `ST_IGNORE`.
- From `ST_ADDR_ACK`: to `ST_RDATA` for a read, otherwise to `ST_PTR`.
- From `ST_PTR`: to `ST_PTR_ACK` for a legal pointer, otherwise to `ST_IGNORE`.
- From `ST_PTR_ACK`: to `ST_WDATA`.
- Between `ST_WDATA` and `ST_WDATA_ACK`: back and forth, one cycle per data byte.
- From `ST_RDATA`: to `ST_RD_ACK`.
- From `ST_RD_ACK`: back to `ST_RDATA` when the master ACKs, otherwise to `ST_IGNORE`.

Top module: `tsense_i2c_slave`

## Requirements
- R1: After reset the registers hold these values: upper trip point 0x5000, lower trip point 0x4B00, configuration 0x00, temperature 0x0000. The pointer selects the temperature register, and `sda_oe` is low.
- R2: The slave acknowledges an address byte by driving `sda_oe` high for the ninth clock. It does so only when bits 7:1 of the byte equal `1001` followed by `addr_strap[2:0]`. Any other address gets no acknowledge, and the slave ignores the bus until the next START or STOP.
- R3: In a write, the byte after the address is the pointer, and it is acknowledged. Bits 1:0 select the register: 0 is temperature, 1 is configuration, 2 is the lower trip point and 3 is the upper trip point.
- R4: A pointer byte with any of bits 7:2 set gets no acknowledge. The transaction is abandoned and the stored pointer keeps its previous value.
- R5: The pointer keeps its value across STOP and START. A read with no pointer write returns the register selected last.
- R6: A read returns 16-bit registers most significant byte first and the configuration as a single byte. After each byte the master's ACK continues the read. The byte order wraps within the register (MSB, LSB, MSB ...), and the configuration byte repeats. A NACK ends the read.
- R7: Write data is handled as follows:
  - Trip-point writes take the MSB, then the LSB.
  - A configuration write takes one byte, with bit 7 forced to 0.
  - Bytes written to the temperature register, and bytes beyond the register's width, are acknowledged and discarded.
- R8: A conversion result is stored as `conv_data & 16'hFF80`. It is stored at once when no read is active. During a read, which runs from the acknowledge of a read address until the master's NACK, the old value stays visible, and the new one is stored once the read ends.
- R9: If SDA stays low for `TIMEOUT_CYCLES` system clocks while a transaction is open, the slave releases SDA and returns to idle. It ignores all bus activity until the next START.
- R10: `read_strobe` pulses high for exactly one cycle each time the master NACKs a byte the slave has sent. It never pulses for a transaction to another address.
- R11: `sda_oe` changes only while SCL is low.
- R12: A repeated START in the middle of a transaction restarts the address phase. The pointer just written is kept, so a read can follow at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| sda_oe | output | 1 | High pulls SDA low (open-drain enable) |
| addr_strap | input | 3 | Low three bits of the device address |
| conv_valid | input | 1 | One-cycle pulse with a new conversion result |
| conv_data | input | 16 | Conversion result, two's complement, 9 MSBs significant |
| temp_o | output | 16 | Stored temperature |
| cfg_o | output | 8 | Configuration register |
| thys_o | output | 16 | Lower trip point |
| tos_o | output | 16 | Upper trip point |
| read_strobe | output | 1 | One-cycle pulse per completed register read |

## Verification
A conversion result can arrive in the very cycle that a temperature read is running. That collision is the case that most needs covering. The bench pulses `conv_valid` just after the slave acknowledges a read address. It then checks three things: `temp_o` keeps its old value, both bytes on the bus carry the old value, and the new value appears only after the master's NACK. The SDA-low watchdog and the acknowledge logic are also exercised together. The slave's own acknowledge pulls SDA low, so the limit has to be longer than any byte of zeros, and a byte clocked in after the timeout must get no acknowledge.

// File: rtl/tsi_pkg.sv
package tsi_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_PTR,
        ST_PTR_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RD_ACK,
        ST_IGNORE
    } bus_state_e;

    localparam logic [1:0] SEL_TEMP = 2'd0;
    localparam logic [1:0] SEL_CFG  = 2'd1;
    localparam logic [1:0] SEL_THYS = 2'd2;
    localparam logic [1:0] SEL_TOS  = 2'd3;

endpackage

// File: rtl/tsi_line_sync.sv
module tsi_line_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    logic [SYNC_STAGES-1:0] scl_pipe;
    logic [SYNC_STAGES-1:0] sda_pipe;
    logic                   scl_d;
    logic                   sda_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_d    <= 1'b1;
            sda_d    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[SYNC_STAGES-2:0], scl_i};
            sda_pipe <= {sda_pipe[SYNC_STAGES-2:0], sda_i};
            scl_d    <= scl_s;
            sda_d    <= sda_s;
        end
    end

    assign scl_s     = scl_pipe[SYNC_STAGES-1];
    assign sda_s     = sda_pipe[SYNC_STAGES-1];
    assign scl_rise  = scl_s & ~scl_d;
    assign scl_fall  = ~scl_s & scl_d;
    // data edges count only while the clock line stays high
    assign start_det = scl_s & scl_d & sda_d & ~sda_s;
    assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;

endmodule

// File: rtl/tsi_timeout.sv
module tsi_timeout #(
    parameter int TIMEOUT_CYCLES = 5_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bus_active,
    input  logic sda_s,
    output logic tmo_hit
);

    localparam int CW = $clog2(TIMEOUT_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(TIMEOUT_CYCLES - 1);

    logic [CW-1:0] low_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_cnt <= '0;
            tmo_hit <= 1'b0;
        end else begin
            tmo_hit <= 1'b0;
            if (!bus_active || sda_s) begin
                low_cnt <= '0;
            end else if (low_cnt == LAST) begin
                low_cnt <= '0;
                tmo_hit <= 1'b1;
            end else begin
                low_cnt <= low_cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/tsi_regfile.sv
module tsi_regfile
    import tsi_pkg::*;
#(
    parameter logic [15:0] TOS_INIT  = 16'h5000,
    parameter logic [15:0] THYS_INIT = 16'h4B00,
    parameter logic [7:0]  CFG_INIT  = 8'h00,
    parameter logic [7:0]  CFG_WMASK = 8'h7F,
    parameter logic [15:0] TEMP_MASK = 16'hFF80
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [1:0]  wr_sel,
    input  logic        wr_lsb,
    input  logic [7:0]  wr_data,
    input  logic        conv_valid,
    input  logic [15:0] conv_data,
    input  logic        read_busy,
    input  logic [1:0]  rd_sel,
    input  logic        rd_lsb,
    output logic [7:0]  rd_byte,
    output logic [15:0] temp_o,
    output logic [7:0]  cfg_o,
    output logic [15:0] thys_o,
    output logic [15:0] tos_o
);

    logic [15:0] temp_q, thys_q, tos_q, pend_q, word;
    logic [7:0]  cfg_q;
    logic        pend_v;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q  <= CFG_INIT;
            thys_q <= THYS_INIT;
            tos_q  <= TOS_INIT;
        end else if (wr_en) begin
            unique case (wr_sel)
                SEL_CFG:  cfg_q <= wr_data & CFG_WMASK;
                SEL_THYS: if (wr_lsb) thys_q[7:0] <= wr_data;
                          else        thys_q[15:8] <= wr_data;
                SEL_TOS:  if (wr_lsb) tos_q[7:0] <= wr_data;
                          else        tos_q[15:8] <= wr_data;
                default:  ;
            endcase
        end
    end

    // capture path: a result arriving during a read waits in pend_q
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            temp_q <= '0;
            pend_q <= '0;
            pend_v <= 1'b0;
        end else if (conv_valid) begin
            if (read_busy) begin
                pend_q <= conv_data & TEMP_MASK;
                pend_v <= 1'b1;
            end else begin
                temp_q <= conv_data & TEMP_MASK;
                pend_v <= 1'b0;
            end
        end else if (pend_v && !read_busy) begin
            temp_q <= pend_q;
            pend_v <= 1'b0;
        end
    end

    always_comb begin
        unique case (rd_sel)
            SEL_TEMP: word = temp_q;
            SEL_THYS: word = thys_q;
            SEL_TOS:  word = tos_q;
            default:  word = {cfg_q, cfg_q};
        endcase
        rd_byte = rd_lsb ? word[7:0] : word[15:8];
    end

    assign temp_o = temp_q;
    assign cfg_o  = cfg_q;
    assign thys_o = thys_q;
    assign tos_o  = tos_q;

endmodule

// File: rtl/tsi_bus_fsm.sv
module tsi_bus_fsm
    import tsi_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_rise,
    input  logic       scl_fall,
    input  logic       start_det,
    input  logic       stop_det,
    input  logic       sda_s,
    input  logic       tmo_hit,
    input  logic [6:0] dev_addr,
    input  logic [7:0] rd_byte,
    output logic       sda_oe,
    output logic       wr_en,
    output logic [1:0] wr_sel,
    output logic       wr_lsb,
    output logic [7:0] wr_data,
    output logic [1:0] sel,
    output logic       rd_lsb,
    output logic       read_busy,
    output logic       read_strobe,
    output logic       bus_active
);

    bus_state_e state, nxt;
    logic [7:0] shreg, txsh;
    logic [3:0] bitcnt;
    logic [1:0] byte_idx, wr_limit;
    logic [1:0] ptr_q;
    logic       rw_q, mack_q;
    logic       byte_full, addr_hit, ptr_ok;

    assign byte_full = (bitcnt == 4'd8);
    assign addr_hit  = (shreg[7:1] == dev_addr);
    assign ptr_ok    = (shreg[7:2] == 6'd0);
    assign wr_limit  = (ptr_q == SEL_CFG) ? 2'd1 : 2'd2;

    // next-state logic
    always_comb begin
        nxt = state;
        if (tmo_hit) begin
            nxt = ST_IDLE;
        end else if (start_det) begin
            nxt = ST_ADDR;
        end else if (stop_det) begin
            nxt = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:      nxt = ST_IDLE;
                ST_ADDR:      if (scl_fall && byte_full) nxt = addr_hit ? ST_ADDR_ACK : ST_IGNORE;
                ST_ADDR_ACK:  if (scl_fall) nxt = rw_q ? ST_RDATA : ST_PTR;
                ST_PTR:       if (scl_fall && byte_full) nxt = ptr_ok ? ST_PTR_ACK : ST_IGNORE;
                ST_PTR_ACK:   if (scl_fall) nxt = ST_WDATA;
                ST_WDATA:     if (scl_fall && byte_full) nxt = ST_WDATA_ACK;
                ST_WDATA_ACK: if (scl_fall) nxt = ST_WDATA;
                ST_RDATA:     if (scl_fall && byte_full) nxt = ST_RD_ACK;
                ST_RD_ACK:    if (scl_fall) nxt = mack_q ? ST_RDATA : ST_IGNORE;
                ST_IGNORE:    nxt = ST_IGNORE;
                default:      nxt = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sda_oe      <= 1'b0;
            shreg       <= '0;
            txsh        <= '0;
            bitcnt      <= '0;
            byte_idx    <= '0;
            ptr_q       <= SEL_TEMP;
            rw_q        <= 1'b0;
            mack_q      <= 1'b0;
            wr_en       <= 1'b0;
            wr_data     <= '0;
            read_strobe <= 1'b0;
        end else begin
            wr_en       <= 1'b0;
            read_strobe <= 1'b0;
            if (tmo_hit || stop_det) begin
                sda_oe <= 1'b0;
                bitcnt <= '0;
            end else if (start_det) begin
                sda_oe   <= 1'b0;
                bitcnt   <= '0;
                byte_idx <= '0;
            end else begin
                unique case (state)
                    ST_ADDR, ST_PTR, ST_WDATA: begin
                        if (scl_rise && !byte_full) begin
                            shreg  <= {shreg[6:0], sda_s};
                            bitcnt <= bitcnt + 4'd1;
                        end
                        if (scl_fall && byte_full) begin
                            if (state == ST_ADDR) begin
                                if (addr_hit) begin
                                    sda_oe <= 1'b1;
                                    rw_q   <= shreg[0];
                                end
                            end else if (state == ST_PTR) begin
                                if (ptr_ok) begin
                                    sda_oe <= 1'b1;
                                    ptr_q  <= shreg[1:0];
                                end
                            end else begin
                                sda_oe  <= 1'b1;
                                wr_data <= shreg;
                                wr_en   <= (byte_idx < wr_limit);
                            end
                        end
                    end
                    ST_ADDR_ACK, ST_PTR_ACK, ST_WDATA_ACK: begin
                        if (scl_fall) begin
                            bitcnt <= '0;
                            if (state == ST_ADDR_ACK && rw_q) begin
                                txsh   <= rd_byte;
                                sda_oe <= ~rd_byte[7];
                            end else begin
                                sda_oe <= 1'b0;
                            end
                            if (state == ST_WDATA_ACK) begin
                                if (byte_idx != 2'd2) byte_idx <= byte_idx + 2'd1;
                            end else begin
                                byte_idx <= '0;
                            end
                        end
                    end
                    ST_RDATA: begin
                        if (scl_rise && !byte_full) bitcnt <= bitcnt + 4'd1;
                        if (scl_fall) begin
                            if (byte_full) begin
                                sda_oe <= 1'b0;
                            end else begin
                                txsh   <= {txsh[6:0], 1'b0};
                                sda_oe <= ~txsh[6];
                            end
                        end
                    end
                    ST_RD_ACK: begin
                        if (scl_rise) begin
                            mack_q <= ~sda_s;
                            if (sda_s) read_strobe <= 1'b1;
                            else       byte_idx    <= {1'b0, ~byte_idx[0]};
                        end
                        if (scl_fall && mack_q) begin
                            bitcnt <= '0;
                            txsh   <= rd_byte;
                            sda_oe <= ~rd_byte[7];
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign wr_sel     = ptr_q;
    assign wr_lsb     = byte_idx[0];
    assign sel        = ptr_q;
    assign rd_lsb     = byte_idx[0];
    assign bus_active = (state != ST_IDLE);
    assign read_busy  = (state == ST_RDATA) || (state == ST_RD_ACK) ||
                        (state == ST_ADDR_ACK && rw_q);

endmodule

// File: rtl/tsense_i2c_slave.sv
module tsense_i2c_slave
    import tsi_pkg::*;
#(
    parameter int          TIMEOUT_CYCLES = 5_000_000,
    parameter int          SYNC_STAGES    = 2,
    parameter logic [3:0]  ADDR_PREFIX    = 4'b1001
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        scl_i,
    input  logic        sda_i,
    output logic        sda_oe,
    input  logic [2:0]  addr_strap,
    input  logic        conv_valid,
    input  logic [15:0] conv_data,
    output logic [15:0] temp_o,
    output logic [7:0]  cfg_o,
    output logic [15:0] thys_o,
    output logic [15:0] tos_o,
    output logic        read_strobe
);

    logic       scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic       tmo_hit, bus_active, read_busy;
    logic       wr_en, wr_lsb, rd_lsb;
    logic [1:0] wr_sel, sel;
    logic [7:0] wr_data, rd_byte;
    logic [6:0] dev_addr;

    assign dev_addr = {ADDR_PREFIX, addr_strap};

    tsi_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    tsi_timeout #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) u_tmo (
        .clk(clk), .rst_n(rst_n), .bus_active(bus_active), .sda_s(sda_s),
        .tmo_hit(tmo_hit)
    );

    tsi_bus_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det), .sda_s(sda_s),
        .tmo_hit(tmo_hit), .dev_addr(dev_addr), .rd_byte(rd_byte),
        .sda_oe(sda_oe), .wr_en(wr_en), .wr_sel(wr_sel), .wr_lsb(wr_lsb),
        .wr_data(wr_data), .sel(sel), .rd_lsb(rd_lsb), .read_busy(read_busy),
        .read_strobe(read_strobe), .bus_active(bus_active)
    );

    tsi_regfile u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_lsb(wr_lsb), .wr_data(wr_data), .conv_valid(conv_valid),
        .conv_data(conv_data), .read_busy(read_busy), .rd_sel(sel),
        .rd_lsb(rd_lsb), .rd_byte(rd_byte), .temp_o(temp_o), .cfg_o(cfg_o),
        .thys_o(thys_o), .tos_o(tos_o)
    );

endmodule

// File: rtl/tsi_checker.sv
module tsi_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        scl_i,
    input logic        sda_oe,
    input logic        read_strobe,
    input logic [7:0]  cfg_o,
    input logic [15:0] temp_o,
    input logic        read_busy,
    input logic        tmo_hit
);

    // R11: the data line driver holds still while the clock is high
    p_oe_quiet_scl_high_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_i && $past(scl_i)) |-> $stable(sda_oe));

    // R7: reserved configuration bit never becomes set
    p_cfg_reserved_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_o[7]);

    // R10: strobe is a single-cycle pulse
    p_strobe_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        read_strobe |=> !read_strobe);

    // R8: stored temperature does not move while a read is running
    p_temp_hold_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(read_busy) |-> $stable(temp_o));

    // R9: bus released right after the watchdog fires
    p_timeout_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
        tmo_hit |=> !sda_oe);

endmodule

bind tsense_i2c_slave tsi_checker u_chk (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe(sda_oe),
    .read_strobe(read_strobe), .cfg_o(cfg_o), .temp_o(temp_o),
    .read_busy(read_busy), .tmo_hit(tmo_hit)
);

// File: tb/tsense_i2c_slave_bench.sv
`timescale 1ns/1ps
module tsense_i2c_slave_bench;

    localparam int Q   = 8;
    localparam int TMO = 2000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl_m = 1'b1;
    logic        sda_m = 1'b1;
    logic        sda_oe;
    logic [2:0]  strap = 3'b101;
    logic        conv_valid = 1'b0;
    logic [15:0] conv_data = '0;
    logic [15:0] temp_o, thys_o, tos_o;
    logic [7:0]  cfg_o;
    logic        read_strobe;
    logic        sda_line;

    int nchk = 0;
    int nfail = 0;
    int strobes = 0;
    int oe_viol = 0;
    logic prev_scl = 1'b1, prev_oe = 1'b0;

    assign sda_line = sda_m & ~sda_oe;

    always #10 clk = ~clk;

    tsense_i2c_slave #(.TIMEOUT_CYCLES(TMO)) u_tsense_i2c_slave (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
        .sda_oe(sda_oe), .addr_strap(strap), .conv_valid(conv_valid),
        .conv_data(conv_data), .temp_o(temp_o), .cfg_o(cfg_o),
        .thys_o(thys_o), .tos_o(tos_o), .read_strobe(read_strobe)
    );

    always @(posedge clk) if (read_strobe) strobes <= strobes + 1;

    always @(negedge clk) begin
        if (scl_m && prev_scl && (sda_oe != prev_oe)) oe_viol <= oe_viol + 1;
        prev_scl <= scl_m;
        prev_oe  <= sda_oe;
    end

    task automatic chk(input string req, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    endtask

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic m_start();
        sda_m = 1'b1; wq(Q);
        scl_m = 1'b1; wq(Q);
        sda_m = 1'b0; wq(Q);
        scl_m = 1'b0; wq(Q);
    endtask

    task automatic m_stop();
        sda_m = 1'b0; wq(Q);
        scl_m = 1'b1; wq(Q);
        sda_m = 1'b1; wq(2*Q);
    endtask

    task automatic m_wbit(input logic b);
        sda_m = b; wq(Q);
        scl_m = 1'b1; wq(2*Q);
        scl_m = 1'b0; wq(Q);
    endtask

    task automatic m_rbit(output logic b);
        sda_m = 1'b1; wq(Q);
        scl_m = 1'b1; wq(Q);
        b = sda_line; wq(Q);
        scl_m = 1'b0; wq(Q);
    endtask

    task automatic m_wbyte(input logic [7:0] d, output logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) m_wbit(d[i]);
        m_rbit(b);
        ack = ~b;
    endtask

    task automatic m_rbyte(input logic ack_m, output logic [7:0] d);
        for (int i = 7; i >= 0; i--) m_rbit(d[i]);
        m_wbit(~ack_m);
    endtask

    task automatic conv_pulse(input logic [15:0] v);
        @(negedge clk);
        conv_valid = 1'b1; conv_data = v;
        @(negedge clk);
        conv_valid = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R1 tos", tos_o, 16'h5000);
        chk("R1 thys", thys_o, 16'h4B00);
        chk("R1 cfg", cfg_o, 8'h00);
        chk("R1 temp", temp_o, 16'h0000);
        chk("R1 sda_oe", sda_oe, 0);
    endtask

    task automatic t_addr_and_temp();
        logic a; logic [7:0] hi, lo; int s0;
        s0 = strobes;
        m_start(); m_wbyte(8'h93, a); m_stop();
        chk("R2 foreign address nack", a, 0);
        conv_pulse(16'h1934);
        chk("R8 capture masked", temp_o, 16'h1900);
        m_start(); m_wbyte(8'h9B, a);
        chk("R2 own address ack", a, 1);
        m_rbyte(1'b1, hi); m_rbyte(1'b0, lo); m_stop();
        chk("R1 default pointer temp msb", hi, 8'h19);
        chk("R6 temp lsb", lo, 8'h00);
        chk("R10 one strobe per read", strobes - s0, 1);
    endtask

    task automatic t_tos_restart();
        logic a; logic [7:0] b0, b1, b2;
        m_start(); m_wbyte(8'h9A, a); m_wbyte(8'h03, a);
        chk("R3 pointer ack", a, 1);
        m_wbyte(8'h5A, a); m_wbyte(8'h80, a); m_stop();
        chk("R7 tos write", tos_o, 16'h5A80);
        m_start(); m_wbyte(8'h9A, a); m_wbyte(8'h03, a);
        m_start(); m_wbyte(8'h9B, a);
        chk("R12 repeated start address ack", a, 1);
        m_rbyte(1'b1, b0); m_rbyte(1'b1, b1); m_rbyte(1'b0, b2); m_stop();
        chk("R6 msb first", b0, 8'h5A);
        chk("R6 lsb second", b1, 8'h80);
        chk("R6 wrap to msb", b2, 8'h5A);
    endtask

    task automatic t_cfg();
        logic a; logic [7:0] d;
        m_start(); m_wbyte(8'h9A, a); m_wbyte(8'h01, a); m_wbyte(8'hFF, a); m_stop();
        chk("R7 cfg bit7 forced zero", cfg_o, 8'h7F);
        m_start(); m_wbyte(8'h9A, a); m_wbyte(8'h01, a); m_wbyte(8'h18, a); m_wbyte(8'hFF, a); m_stop();
        chk("R7 extra byte acked", a, 1);
        chk("R7 extra byte discarded", cfg_o, 8'h18);
        m_start(); m_wbyte(8'h9B, a); m_rbyte(1'b0, d); m_stop();
        chk("R5 cfg read without pointer", d, 8'h18);
    endtask

    task automatic t_bad_ptr();
        logic a; logic [7:0] hi, lo;
        m_start(); m_wbyte(8'h9A, a); m_wbyte(8'h02, a); m_stop();
        m_start(); m_wbyte(8'h9A, a); m_wbyte(8'h06, a); m_stop();
        chk("R4 bad pointer nack", a, 0);
        m_start(); m_wbyte(8'h9B, a); m_rbyte(1'b1, hi); m_rbyte(1'b0, lo); m_stop();
        chk("R4 pointer unchanged msb", hi, 8'h4B);
        chk("R5 retained pointer lsb", lo, 8'h00);
    endtask

    task automatic t_temp_ro();
        logic a;
        m_start(); m_wbyte(8'h9A, a); m_wbyte(8'h00, a); m_wbyte(8'hAA, a); m_wbyte(8'h55, a); m_stop();
        chk("R7 temp write acked", a, 1);
        chk("R7 temp write ignored", temp_o, 16'h1900);
    endtask

    task automatic t_defer();
        logic a; logic [7:0] hi, lo;
        m_start(); m_wbyte(8'h9B, a);
        conv_pulse(16'h2580);
        chk("R8 deferred during read", temp_o, 16'h1900);
        m_rbyte(1'b1, hi); m_rbyte(1'b0, lo); m_stop();
        chk("R8 old msb on bus", hi, 8'h19);
        chk("R8 old lsb on bus", lo, 8'h00);
        wq(4);
        chk("R8 applied after read", temp_o, 16'h2580);
    endtask

    task automatic t_timeout();
        logic a; logic [7:0] d;
        m_start(); m_wbyte(8'h9A, a); m_wbyte(8'h01, a); m_stop();
        m_start(); m_wbyte(8'h9A, a);
        sda_m = 1'b0;
        wq(TMO + 500);
        chk("R9 released after timeout", sda_oe, 0);
        m_wbyte(8'h02, a);
        chk("R9 no ack before new start", a, 0);
        m_stop();
        m_start(); m_wbyte(8'h9B, a); m_rbyte(1'b0, d); m_stop();
        chk("R9 pointer kept after timeout", d, 8'h18);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: actual hung expected finished");
        summary();
        $finish;
    end

    initial begin
        wq(5);
        rst_n = 1'b1;
        wq(5);
        t_reset();
        t_addr_and_temp();
        t_tos_restart();
        t_cfg();
        t_bad_ptr();
        t_temp_ro();
        t_defer();
        t_timeout();
        chk("R11 oe changes with scl high", oe_viol, 0);
        summary();
        $finish;
    end

endmodule